// File: doc/BRIEF.md
# SCSI Controller Status Register Bank

This block is the host-visible register bank of a SCSI interface controller. A host reaches sixteen-bit registers through byte offsets on a word-aligned port. Writes go through rules that depend on the register. Some registers keep only a narrow field. One register ignores writes. The connection-status and transfer-status registers combine read-only bits, write-one-to-clear flags and plain bits. The bus side of the controller raises status flags through two set-pulse inputs.

Two summary bits are derived from the status flags. The connection summary covers the bus reset, bus error, odd byte count, buffer, line done and state change flags. The data summary covers the DMA done, transmit buffer empty, input buffer full and phase mismatch flags. Both summary bits appear at the top of both status registers. Together with an enable bit in the control register, they drive a level interrupt. A DMA-control field also selects between asynchronous and synchronous transfer mode.

Top module: `scsiStatusRegs`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `dmaSyncMode` is low.
- R2: An access whose address has bit 1 or bit 0 set is ignored. It changes no register, and its read returns 0.
- R3: A write to offset 0x10 (ID) or 0x14 (selector control) stores only write data bits [2:0]. Bits [15:3] read 0.
- R4: A write to offset 0x24 (DMA control) stores only bits [1:0]. `dmaSyncMode` is high exactly when that stored field is nonzero, and low for 00 (asynchronous).
- R5: A write to offset 0x20 (data) stores only bits [7:0]. Offset 0x18 (selection-detector status) ignores every write and reads 0.
- R6: On a write to offset 0x48 (connection status), bits [13:0] update as follows. A bit in mask 0x3B88 that is written 1 is cleared. Any other bit in mask 0x3BF7 keeps its value. A bit outside 0x3BF7 takes the written value with the 0x3B88 bits forced to 0, so bit 3 always ends at 0.
- R7: On a write to offset 0x4C (transfer status), bits [13:0] update as follows. A bit in mask 0x2C18 that is written 1 is cleared. Any other bit in mask 0x0C17 keeps its value. Remaining bits take the written value with the 0x2C18 bits forced to 0.
- R8: Bit 15 of both status registers is the OR of connection bits 13, 12, 11, 9, 8 and 7 (mask 0x3B80). Bit 14 of both is the OR of transfer bits 13, 11, 10 and 4 (mask 0x2C10). Written values of bits 15:14 have no effect.
- R9: `irq` is high exactly while bit 0 of offset 0x0C (control) is 1 and either summary bit is 1. It follows the registers, so it changes just after the clock edge that updates them.
- R10: At each clock edge, a 1 on `connSet[i]` or `xferSet[i]` sets bit i of the connection or transfer status register. The set is applied after any host write in the same cycle, so a set takes priority over a clear.
- R11: `hostRdata` shows the addressed register in the same cycle that `hostRdEn` is high. It is 0 whenever `hostRdEn` is low.
- R12: Offsets 0x00, 0x0C, 0x50, 0x54 and every other aligned offset with no rule of its own store all 16 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Byte offset of the access |
| hostWrEn | input | 1 | Write strobe |
| hostRdEn | input | 1 | Read strobe |
| hostWdata | input | 16 | Write data |
| hostRdata | output | 16 | Read data, same cycle |
| connSet | input | 14 | Bus-side set pulses for connection status bits |
| xferSet | input | 14 | Bus-side set pulses for transfer status bits |
| dmaSyncMode | output | 1 | High when the DMA control field selects synchronous mode |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a status bit set by the bus side and cleared by the host in the same cycle, so that the set has to win. It is equally hard to reach the point where the last flag under a summary is cleared while the other summary still holds the interrupt up. Directed steps set a flag in each register with the set pulses, enable the interrupt, and then clear the flags one at a time, including once with a coincident set. A long random phase then mixes writes, reads, misaligned offsets and sparse set pulses, and compares every read and the interrupt level against a bench model.

// File: rtl/scsiRegPkg.sv
package scsiRegPkg;
  localparam int DATA_W = 16;
  localparam int FLAG_W = 14;

  // byte offsets decoded by the bank
  localparam logic [7:0] OFF_DIAG    = 8'h00;
  localparam logic [7:0] OFF_CTRL    = 8'h0C;
  localparam logic [7:0] OFF_ID      = 8'h10;
  localparam logic [7:0] OFF_SEL     = 8'h14;
  localparam logic [7:0] OFF_DETECT  = 8'h18;
  localparam logic [7:0] OFF_DATA    = 8'h20;
  localparam logic [7:0] OFF_DMA     = 8'h24;
  localparam logic [7:0] OFF_CONN    = 8'h48;
  localparam logic [7:0] OFF_XFER    = 8'h4C;
  localparam logic [7:0] OFF_CMD     = 8'h50;
  localparam logic [7:0] OFF_DIAGCTL = 8'h54;

  // status bit rules
  localparam logic [DATA_W-1:0] CONN_KEEP = 16'h3BF7;
  localparam logic [DATA_W-1:0] CONN_W1C  = 16'h3B88;
  localparam logic [DATA_W-1:0] CONN_SUM  = 16'h3B80;
  localparam logic [DATA_W-1:0] XFER_KEEP = 16'h0C17;
  localparam logic [DATA_W-1:0] XFER_W1C  = 16'h2C18;
  localparam logic [DATA_W-1:0] XFER_SUM  = 16'h2C10;
  localparam int IE_BIT = 0;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_NARROW3,
    K_BYTE,
    K_NARROW2,
    K_RDONLY,
    K_CONN,
    K_XFER
  } regKind_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    regKind_e kind;
  } hostStrobe_t;
endpackage

// File: rtl/scsiRegControl.sv
module scsiRegControl
  import scsiRegPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  output hostStrobe_t       stb
);
  logic aligned;
  regKind_e kind;

  assign aligned = (hostAddr[1:0] == 2'b00);

  always_comb begin
    if (hostAddr == ADDR_W'(OFF_ID) || hostAddr == ADDR_W'(OFF_SEL))
      kind = K_NARROW3;
    else if (hostAddr == ADDR_W'(OFF_DATA))
      kind = K_BYTE;
    else if (hostAddr == ADDR_W'(OFF_DMA))
      kind = K_NARROW2;
    else if (hostAddr == ADDR_W'(OFF_DETECT))
      kind = K_RDONLY;
    else if (hostAddr == ADDR_W'(OFF_CONN))
      kind = K_CONN;
    else if (hostAddr == ADDR_W'(OFF_XFER))
      kind = K_XFER;
    else
      kind = K_PLAIN;
  end

  assign stb.wr   = hostWrEn & aligned;
  assign stb.rd   = hostRdEn & aligned;
  assign stb.kind = kind;
endmodule

// File: rtl/scsiRegDatapath.sv
module scsiRegDatapath
  import scsiRegPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         stb,
  input  logic [ADDR_W-3:0]   slot,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [FLAG_W-1:0]   connSet,
  input  logic [FLAG_W-1:0]   xferSet,
  output logic [DATA_W-1:0]   rdata,
  output logic                dmaSync,
  output logic                irq
);
  localparam int SLOT_W    = ADDR_W - 2;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int CTRL_SLOT = int'(OFF_CTRL) >> 2;
  localparam int DMA_SLOT  = int'(OFF_DMA) >> 2;

  logic [DATA_W-1:0] bank [NUM_SLOTS];
  logic [DATA_W-1:0] storeVal;
  logic              storeEn;
  logic [FLAG_W-1:0] connReg, xferReg, connNext, xferNext;
  logic [FLAG_W-1:0] wLow;
  logic              connSum, xferSum;
  logic [DATA_W-1:0] rdVal;

  // value stored into the plain bank for each kind of register
  always_comb begin
    unique case (stb.kind)
      K_NARROW3: storeVal = {13'd0, wdata[2:0]};
      K_BYTE:    storeVal = {8'd0, wdata[7:0]};
      K_NARROW2: storeVal = {14'd0, wdata[1:0]};
      default:   storeVal = wdata;
    endcase
  end

  assign storeEn = stb.wr && (stb.kind == K_PLAIN || stb.kind == K_NARROW3 ||
                              stb.kind == K_BYTE  || stb.kind == K_NARROW2);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        bank[s] <= '0;
      else if (storeEn && slot == SLOT_W'(s))
        bank[s] <= storeVal;
    end
  end

  // status registers: write rules first, bus-side sets afterwards
  assign wLow = wdata[FLAG_W-1:0];

  always_comb begin
    connNext = connReg;
    xferNext = xferReg;
    if (stb.wr && stb.kind == K_CONN)
      connNext = (wLow & ~CONN_W1C[FLAG_W-1:0] & ~CONN_KEEP[FLAG_W-1:0]) |
                 (connReg & CONN_KEEP[FLAG_W-1:0] & ~(wLow & CONN_W1C[FLAG_W-1:0]));
    if (stb.wr && stb.kind == K_XFER)
      xferNext = (wLow & ~XFER_W1C[FLAG_W-1:0] & ~XFER_KEEP[FLAG_W-1:0]) |
                 (xferReg & XFER_KEEP[FLAG_W-1:0] & ~(wLow & XFER_W1C[FLAG_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      connReg <= '0;
      xferReg <= '0;
    end else begin
      connReg <= connNext | connSet;
      xferReg <= xferNext | xferSet;
    end
  end

  assign connSum = |(connReg & CONN_SUM[FLAG_W-1:0]);
  assign xferSum = |(xferReg & XFER_SUM[FLAG_W-1:0]);

  always_comb begin
    unique case (stb.kind)
      K_CONN:  rdVal = {connSum, xferSum, connReg};
      K_XFER:  rdVal = {connSum, xferSum, xferReg};
      default: rdVal = bank[slot];
    endcase
  end

  assign rdata   = stb.rd ? rdVal : '0;
  assign dmaSync = |bank[DMA_SLOT][1:0];
  assign irq     = bank[CTRL_SLOT][IE_BIT] & (connSum | xferSum);
endmodule

// File: rtl/scsiStatusRegs.sv
module scsiStatusRegs
  import scsiRegPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  input  logic [13:0]       connSet,
  input  logic [13:0]       xferSet,
  output logic              dmaSyncMode,
  output logic              irq
);
  hostStrobe_t stb;

  scsiRegControl #(.ADDR_W(ADDR_W)) ctrl (
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .hostAddr (hostAddr),
    .stb      (stb)
  );

  scsiRegDatapath #(.ADDR_W(ADDR_W)) dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .slot    (hostAddr[ADDR_W-1:2]),
    .wdata   (hostWdata),
    .connSet (connSet),
    .xferSet (xferSet),
    .rdata   (hostRdata),
    .dmaSync (dmaSyncMode),
    .irq     (irq)
  );
endmodule

// File: rtl/scsiStatusRegsChecker.sv
module scsiStatusRegsChecker
  import scsiRegPkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic              ctrlWrIe,
  input logic [15:0]       hostRdata,
  input logic              dmaSyncMode,
  input logic              irq
);
  logic rdAt;
  assign rdAt = hostRdEn && rstN;

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr[1:0] != 2'b00) |-> hostRdata == 16'd0); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |-> hostRdata == 16'd0); // R11
  AST_ID_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && (hostAddr == ADDR_W'(OFF_ID) || hostAddr == ADDR_W'(OFF_SEL)))
      |-> hostRdata[15:3] == 13'd0); // R3
  AST_DMA_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_DMA)) |-> hostRdata[15:2] == 14'd0); // R4
  AST_DMA_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_DMA)) |-> dmaSyncMode == (hostRdata != 16'd0)); // R4
  AST_DATA_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_DATA)) |-> hostRdata[15:8] == 8'd0); // R5
  AST_DETECT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_DETECT)) |-> hostRdata == 16'd0); // R5
  AST_CONN_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_CONN)) |-> hostRdata[15] == |(hostRdata & CONN_SUM)); // R8
  AST_XFER_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_XFER)) |-> hostRdata[14] == |(hostRdata & XFER_SUM)); // R8
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_W'(OFF_CTRL) && !ctrlWrIe) |=> !irq); // R9
  AST_IRQ_NEEDS_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt && hostAddr == ADDR_W'(OFF_CONN) && hostRdata[15:14] == 2'b00) |-> !irq); // R9
endmodule

bind scsiStatusRegs scsiStatusRegsChecker #(.ADDR_W(ADDR_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostAddr    (hostAddr),
  .hostWrEn    (hostWrEn),
  .hostRdEn    (hostRdEn),
  .ctrlWrIe    (hostWdata[0]),
  .hostRdata   (hostRdata),
  .dmaSyncMode (dmaSyncMode),
  .irq         (irq)
);

// File: tb/scsiStatusRegs_test.sv
module scsiStatusRegs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [13:0] connSet = '0;
  logic [13:0] xferSet = '0;
  logic        dmaSyncMode;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // bench model
  logic [15:0] mdl [32];
  logic [13:0] mConn = '0;
  logic [13:0] mXfer = '0;

  scsiStatusRegs #(.ADDR_W(7)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .connSet(connSet), .xferSet(xferSet), .dmaSyncMode(dmaSyncMode), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic mConnSum();
    return |({2'b00, mConn} & 16'h3B80);
  endfunction
  function automatic logic mXferSum();
    return |({2'b00, mXfer} & 16'h2C10);
  endfunction
  function automatic logic expIrq();
    return mdl[3][0] & (mConnSum() | mXferSum());
  endfunction

  function automatic logic [15:0] expRead(input logic [6:0] a);
    if (a[1:0] != 2'b00) return 16'd0;
    case (a)
      7'h48: return {mConnSum(), mXferSum(), mConn};
      7'h4C: return {mConnSum(), mXferSum(), mXfer};
      default: return mdl[a[6:2]];
    endcase
  endfunction

  function automatic logic [13:0] statusWrite(input logic [13:0] old, input logic [15:0] w,
                                              input logic [15:0] keep, input logic [15:0] clr);
    logic [13:0] res;
    for (int b = 0; b < 14; b++) begin
      if (clr[b] && w[b])       res[b] = 1'b0;
      else if (keep[b])         res[b] = old[b];
      else if (clr[b])          res[b] = 1'b0;
      else                      res[b] = w[b];
    end
    return res;
  endfunction

  task automatic modelWrite(input logic [6:0] a, input logic [15:0] w);
    if (a[1:0] != 2'b00) return;
    case (a)
      7'h10, 7'h14: mdl[a[6:2]] = {13'd0, w[2:0]};
      7'h18: ;
      7'h20: mdl[a[6:2]] = {8'd0, w[7:0]};
      7'h24: mdl[a[6:2]] = {14'd0, w[1:0]};
      7'h48: mConn = statusWrite(mConn, w, 16'h3BF7, 16'h3B88);
      7'h4C: mXfer = statusWrite(mXfer, w, 16'h0C17, 16'h2C18);
      default: mdl[a[6:2]] = w;
    endcase
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at the falling edge, compare, update model after the rising edge
  task automatic op(input bit wr, input bit rd, input logic [6:0] a, input logic [15:0] w,
                    input logic [13:0] cs, input logic [13:0] xs, input string tag);
    @(negedge clk);
    chk(irq === expIrq(), "R9 irq level", {15'd0, irq}, {15'd0, expIrq()});
    chk(dmaSyncMode === (mdl[9][1:0] != 2'b00), "R4 sync mode",
        {15'd0, dmaSyncMode}, {15'd0, (mdl[9][1:0] != 2'b00)});
    hostWrEn = wr; hostRdEn = rd; hostAddr = a; hostWdata = w;
    connSet = cs; xferSet = xs;
    #1;
    if (rd) chk(hostRdata === expRead(a), tag, hostRdata, expRead(a));
    else    chk(hostRdata === 16'd0, "R11 idle read data", hostRdata, 16'd0);
    @(posedge clk);
    if (wr) modelWrite(a, w);
    mConn = mConn | cs;
    mXfer = mXfer | xs;
  endtask

  task automatic wrReg(input logic [6:0] a, input logic [15:0] w);
    op(1'b1, 1'b0, a, w, '0, '0, "write");
  endtask
  task automatic rdReg(input logic [6:0] a, input string tag);
    op(1'b0, 1'b1, a, '0, '0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [6:0] mapped [11];
    mapped = '{7'h00, 7'h0C, 7'h10, 7'h14, 7'h18, 7'h20, 7'h24, 7'h48, 7'h4C, 7'h50, 7'h54};
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    void'($urandom(32'h5C51));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 11; i++) rdReg(mapped[i], "R1 reset value");

    // R12: full-width storage
    wrReg(7'h50, 16'hBEEF); rdReg(7'h50, "R12 command readback");
    wrReg(7'h3C, 16'hA5A5); rdReg(7'h3C, "R12 unmapped readback");
    wrReg(7'h54, 16'h00F3); rdReg(7'h54, "R12 diag control readback");

    // R3: narrow fields
    wrReg(7'h10, 16'hFFFF); rdReg(7'h10, "R3 id keeps 3 bits");
    wrReg(7'h14, 16'h00FD); rdReg(7'h14, "R3 selector keeps 3 bits");

    // R4: dma mode
    wrReg(7'h24, 16'h0000); rdReg(7'h24, "R4 async");
    wrReg(7'h24, 16'hFFFE); rdReg(7'h24, "R4 sync keeps 2 bits");

    // R5: data byte, detector read-only
    wrReg(7'h20, 16'h1234); rdReg(7'h20, "R5 data byte");
    wrReg(7'h18, 16'hFFFF); rdReg(7'h18, "R5 detector ignores write");

    // R2: misaligned
    wrReg(7'h52, 16'h0000); rdReg(7'h50, "R2 misaligned write ignored");
    wrReg(7'h11, 16'h0000); rdReg(7'h10, "R2 misaligned id write ignored");
    rdReg(7'h51, "R2 misaligned read zero");

    // R10, R8: bus-side sets and summaries
    op(1'b0, 1'b0, 7'h00, '0, 14'h2000, 14'h0000, "R10 set");
    rdReg(7'h48, "R10 R8 connection flag and summary");
    op(1'b0, 1'b0, 7'h00, '0, 14'h0000, 14'h0800, "R10 set");
    rdReg(7'h4C, "R10 R8 transfer flag and mirrored summaries");

    // R9: interrupt enable and clearing flags one at a time
    wrReg(7'h0C, 16'h0001);
    rdReg(7'h0C, "R9 enable written");
    wrReg(7'h48, 16'h2000); rdReg(7'h48, "R6 w1c clears bit 13");
    rdReg(7'h4C, "R8 data summary still holds");
    wrReg(7'h4C, 16'h0800); rdReg(7'h4C, "R7 w1c clears bit 11");
    rdReg(7'h48, "R9 irq dropped after last flag");

    // R10: set beats clear in the same cycle
    op(1'b1, 1'b0, 7'h48, 16'h2000, 14'h2000, 14'h0000, "R10 set vs clear");
    rdReg(7'h48, "R10 set wins over clear");
    op(1'b1, 1'b0, 7'h4C, 16'h2000, 14'h0000, 14'h2000, "R10 set vs clear");
    rdReg(7'h4C, "R10 transfer set wins");

    // R6, R7: keep, plain and forced-zero bits
    op(1'b0, 1'b0, 7'h00, '0, 14'h3FFF, 14'h3FFF, "set all");
    wrReg(7'h48, 16'h0000); rdReg(7'h48, "R6 zero write keeps read-only bits");
    wrReg(7'h48, 16'hC408); rdReg(7'h48, "R6 plain bit 10 and bit 3");
    wrReg(7'h4C, 16'h0000); rdReg(7'h4C, "R7 zero write");
    wrReg(7'h4C, 16'h13E8); rdReg(7'h4C, "R7 plain bits and forced zero");
    wrReg(7'h48, 16'hFFFF); rdReg(7'h48, "R8 R6 all ones write");
    wrReg(7'h4C, 16'hFFFF); rdReg(7'h4C, "R8 R7 all ones write");
    wrReg(7'h0C, 16'h0000); rdReg(7'h48, "R9 disabled");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a;
      logic [15:0] w;
      logic [13:0] cs, xs;
      int pick;
      pick = int'($urandom % 16);
      if (pick < 11)       a = mapped[pick];
      else if (pick < 14)  a = 7'(($urandom % 32) << 2);
      else                 a = 7'($urandom % 128);
      w  = 16'($urandom);
      cs = ($urandom % 6 == 0) ? 14'(1 << ($urandom % 14)) : 14'd0;
      xs = ($urandom % 6 == 0) ? 14'(1 << ($urandom % 14)) : 14'd0;
      case ($urandom % 3)
        0: op(1'b1, 1'b0, a, w, cs, xs, "R6 R7 R12 random write");
        1: op(1'b0, 1'b1, a, w, cs, xs, "R3 R5 R8 random read");
        default: op(1'b1, 1'b1, a, w, cs, xs, "R11 random read during write");
      endcase
    end

    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0; connSet = '0; xferSet = '0;
    chk(irq === expIrq(), "R9 final irq", {15'd0, irq}, {15'd0, expIrq()});
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule